// File: doc/BRIEF.md
# Pipelined Byzantine-Tolerant Tick Generator Node

This block is one node of a distributed clock built from n = 3F+1 identical nodes. Correct operation must survive up to F nodes that send arbitrary values. Each node hears tick messages from every node, itself included. A message carries a signed tick index and the identity of its sender. The node keeps a local tick counter and advances it by threshold rules over the highest index seen from each peer. It broadcasts its own indices one at a time on a valid/ready output. The local counter doubles as the node's clock value.

The node does not wait for the previous tick to be acknowledged before it sends the next one. Up to X ticks may be in flight. A node may issue tick k+1 once a 2F+1 quorum has reached tick k−X. If F+1 peers are already ahead of the node, it jumps forward to their level and sends every index it skipped, so the outgoing stream never has a gap. After reset the node first sends the start-up indices −X through 0. The message network, link delays and the detection of faulty nodes are handled outside this block.

Top module: `tick_pipe_node`

## Requirements
- R1: In the first cycle after rst_n is released, local_tick is 0, tx_valid is 1 and tx_tick is −X.
- R2: After reset the node sends the indices −X, −X+1, …, 0 in ascending order, one per accepted handshake (tx_valid and tx_ready both 1 at a clock edge). If no rule holds afterwards, tx_valid drops to 0.
- R3: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_tick keeps its value.
- R4: For each peer the node keeps the highest index received from it. A message whose index is lower than or equal to the stored value has no effect.
- R5: Advance rule. When 2F+1 distinct peers hold a stored index of at least local_tick−X, the node sends local_tick+1 and local_tick increases by one.
- R6: Peers are counted by source identity (rx_src in 0..N−1). Repeated messages from one peer count once toward any threshold.
- R7: Catch-up rule. Let ℓ be the (F+1)-th largest stored peer index. When ℓ is greater than local_tick, local_tick takes the value ℓ in the cycle the rule fires, and the node sends every index from the old local_tick+1 up to ℓ in ascending order.
- R8: With only F peers above local_tick, the catch-up rule does not fire.
- R9: When both rules hold in the same cycle, the catch-up rule wins: local_tick jumps to ℓ rather than to local_tick+1.
- R10: No rule is evaluated while a send is still in progress. Every index is sent exactly once, and the outgoing stream is consecutive: each sent index is the previous one plus one, and no sent index exceeds local_tick.
- R11: Tick indices are W-bit two's complement values, and every comparison is signed. At local_tick 0, a peer index of −X counts as reaching local_tick−X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received tick message is present this cycle |
| rx_src | input | SW = clog2(N) | Sender identity, 0..N−1 |
| rx_tick | input | W | Signed tick index of the received message |
| tx_valid | output | 1 | An outgoing tick index is offered |
| tx_ready | input | 1 | The network accepts the offered index |
| tx_tick | output | W | Signed tick index being sent |
| local_tick | output | W | Signed local tick counter, the node's clock value |

## Verification
A corrupted per-peer register or a wrong order statistic shows up at the ports as a wrong jump target. This happens two clocks after the message that completes a quorum: local_tick lands on the wrong value and the burst ends at the wrong index. A rule that fires while a burst is still being sent, or a lost priority, shows up as a gap or a repeat in tx_tick. It also shows as local_tick moving by one where a jump was due, at the first handshake of the next burst. Every mismatch therefore appears within a few cycles of the stimulus that causes it, and each outgoing index is compared against an independently built expected stream.

// File: rtl/tick_pipe_pkg.sv
// Package: shared types for the pipelined tick generator node.
// Assumes: nothing beyond IEEE 1800-2017.
package tick_pipe_pkg;

    // Rule selected for the current cycle after arbitration.
    typedef enum logic [1:0] {
        RULE_NONE    = 2'd0,
        RULE_CATCHUP = 2'd1,
        RULE_ADVANCE = 2'd2
    } rule_e;

    // Emitter activity: sending a run of indices or waiting for a rule.
    typedef enum logic {
        EM_IDLE = 1'b0,
        EM_SEND = 1'b1
    } em_state_e;

endpackage

// File: rtl/tick_pipe_peer_table.sv
// Module: tick_pipe_peer_table
// Keeps, for every peer, the highest signed tick index received from it.
// Assumes: at most one message per cycle; rx_src values of N or above are
// dropped; registers start below -X so an empty slot never counts toward
// a threshold.
module tick_pipe_peer_table #(
    parameter int N  = 4,
    parameter int X  = 2,
    parameter int W  = 16,
    parameter int SW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [SW-1:0]       rx_src,
    input  logic signed [W-1:0] rx_tick,
    output logic signed [W-1:0] peer_max [N]
);

    localparam int EMPTY_I = -X - 1;
    localparam logic signed [W-1:0] EMPTY = W'(EMPTY_I);

    for (genvar i = 0; i < N; i++) begin : g_peer
        logic signed [W-1:0] max_q;
        logic                hit;

        // Decide whether this message targets this slot and raises it.
        assign hit = rx_valid && (int'(rx_src) == i) && (rx_tick > max_q);

        // Hold the running maximum for peer i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                max_q <= EMPTY;
            end else if (hit) begin
                max_q <= rx_tick;
            end
        end

        assign peer_max[i] = max_q;
    end

endmodule

// File: rtl/tick_pipe_quorum.sv
// Module: tick_pipe_quorum
// Combinational counting network over the per-peer maxima. It yields the
// (F+1)-th largest stored index (catch-up target) and whether 2F+1 peers
// have reached cur_k - X (advance rule).
// Assumes: N = 3F+1; values cannot wrap within the W-bit signed range.
module tick_pipe_quorum #(
    parameter int N = 4,
    parameter int F = 1,
    parameter int X = 2,
    parameter int W = 16
) (
    input  logic signed [W-1:0] peer_max [N],
    input  logic signed [W-1:0] cur_k,
    output logic                catch_hit,
    output logic signed [W-1:0] catch_target,
    output logic                adv_hit
);

    localparam int CW = $clog2(N + 1);
    localparam logic signed [W-1:0] XS = W'(X);

    logic [N-1:0]        rank_ok;
    logic [N-1:0]        reach;
    logic signed [W-1:0] floor_v;
    logic [CW-1:0]       reach_cnt;

    assign floor_v = cur_k - XS;

    for (genvar i = 0; i < N; i++) begin : g_rank
        logic [CW-1:0] above_c;
        logic [CW-1:0] atleast_c;

        // Count peers strictly above and at-or-above peer i's value.
        always_comb begin
            above_c   = '0;
            atleast_c = '0;
            for (int j = 0; j < N; j++) begin
                if (peer_max[j] > peer_max[i]) above_c = above_c + CW'(1);
                if (peer_max[j] >= peer_max[i]) atleast_c = atleast_c + CW'(1);
            end
        end

        // Peer i holds the (F+1)-th largest value when ranks straddle F+1.
        assign rank_ok[i] = (int'(above_c) <= F) && (int'(atleast_c) >= F + 1);
        assign reach[i]   = (peer_max[i] >= floor_v);
    end

    // Pick the (F+1)-th largest value from the lowest qualifying slot.
    always_comb begin
        catch_target = peer_max[0];
        for (int i = N - 1; i >= 0; i--) begin
            if (rank_ok[i]) catch_target = peer_max[i];
        end
    end

    // Count peers that have reached the advance floor.
    always_comb begin
        reach_cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (reach[i]) reach_cnt = reach_cnt + CW'(1);
        end
    end

    assign catch_hit = (catch_target > cur_k);
    assign adv_hit   = (int'(reach_cnt) >= 2 * F + 1);

endmodule

// File: rtl/tick_pipe_emitter.sv
// Module: tick_pipe_emitter
// Owns the local tick counter and the outgoing index run. A fired rule
// loads a run [k+1 .. new k] and moves k at once; the run is then sent
// one index per accepted handshake. Reset loads the start-up run [-X .. 0].
// Assumes: rule is RULE_NONE whenever busy is high.
module tick_pipe_emitter
    import tick_pipe_pkg::*;
#(
    parameter int X = 2,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rule_e               rule,
    input  logic signed [W-1:0] catch_target,
    input  logic                tx_ready,
    output logic                busy,
    output logic                tx_valid,
    output logic signed [W-1:0] tx_tick,
    output logic signed [W-1:0] cur_k
);

    localparam int START_I = -X;
    localparam logic signed [W-1:0] START = W'(START_I);
    localparam logic signed [W-1:0] ONE   = W'(1);

    em_state_e           state_q;
    logic signed [W-1:0] next_q;
    logic signed [W-1:0] last_q;
    logic signed [W-1:0] k_q;
    logic                run_done;

    assign run_done = tx_ready && (next_q == last_q);

    // Advance through the current run, or load a new one on a fired rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EM_SEND;
            next_q  <= START;
            last_q  <= '0;
            k_q     <= '0;
        end else if (state_q == EM_SEND) begin
            if (run_done) begin
                state_q <= EM_IDLE;
            end else if (tx_ready) begin
                next_q <= next_q + ONE;
            end
        end else begin
            unique case (rule)
                RULE_CATCHUP: begin
                    state_q <= EM_SEND;
                    next_q  <= k_q + ONE;
                    last_q  <= catch_target;
                    k_q     <= catch_target;
                end
                RULE_ADVANCE: begin
                    state_q <= EM_SEND;
                    next_q  <= k_q + ONE;
                    last_q  <= k_q + ONE;
                    k_q     <= k_q + ONE;
                end
                default: begin
                    state_q <= EM_IDLE;
                end
            endcase
        end
    end

    assign busy     = (state_q == EM_SEND);
    assign tx_valid = busy;
    assign tx_tick  = next_q;
    assign cur_k    = k_q;

endmodule

// File: rtl/tick_pipe_node.sv
// Module: tick_pipe_node (top)
// One node of an N = 3F+1 fault-tolerant distributed clock. Tracks peer
// maxima, evaluates the catch-up and advance rules while idle (catch-up
// first), and sends its own tick indices over a valid/ready port.
// Assumes: at most one incoming message per cycle; X > 1.
module tick_pipe_node
    import tick_pipe_pkg::*;
#(
    parameter int F = 1,
    parameter int X = 2,
    parameter int W = 16,
    localparam int N  = 3 * F + 1,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic [SW-1:0]       rx_src,
    input  logic signed [W-1:0] rx_tick,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic signed [W-1:0] tx_tick,
    output logic signed [W-1:0] local_tick
);

    logic signed [W-1:0] peer_max [N];
    logic signed [W-1:0] cur_k;
    logic signed [W-1:0] catch_target;
    logic                catch_hit;
    logic                adv_hit;
    logic                busy;
    rule_e               rule;

    tick_pipe_peer_table #(.N(N), .X(X), .W(W), .SW(SW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_src   (rx_src),
        .rx_tick  (rx_tick),
        .peer_max (peer_max)
    );

    tick_pipe_quorum #(.N(N), .F(F), .X(X), .W(W)) u_quorum (
        .peer_max     (peer_max),
        .cur_k        (cur_k),
        .catch_hit    (catch_hit),
        .catch_target (catch_target),
        .adv_hit      (adv_hit)
    );

    // Arbitrate the rules: none while sending, catch-up before advance.
    always_comb begin
        if (busy)           rule = RULE_NONE;
        else if (catch_hit) rule = RULE_CATCHUP;
        else if (adv_hit)   rule = RULE_ADVANCE;
        else                rule = RULE_NONE;
    end

    tick_pipe_emitter #(.X(X), .W(W)) u_emit (
        .clk          (clk),
        .rst_n        (rst_n),
        .rule         (rule),
        .catch_target (catch_target),
        .tx_ready     (tx_ready),
        .busy         (busy),
        .tx_valid     (tx_valid),
        .tx_tick      (tx_tick),
        .cur_k        (cur_k)
    );

    assign local_tick = cur_k;

endmodule

// File: rtl/tick_pipe_node_chk.sv
// Module: tick_pipe_node_chk
// Port-level properties of the tick generator node, bound to the top.
// Assumes: synchronous active-low reset; observes ports only.
module tick_pipe_node_chk #(
    parameter int X = 2,
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic signed [W-1:0] tx_tick,
    input logic signed [W-1:0] local_tick
);

    localparam int START_I = -X;
    localparam logic signed [W-1:0] START = W'(START_I);

    logic                was_run;
    logic                sent_any;
    logic signed [W-1:0] last_sent;
    logic signed [W-1:0] prev_k;

    // Remember the previous cycle's reset state, sent index and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_run   <= 1'b0;
            sent_any  <= 1'b0;
            last_sent <= '0;
            prev_k    <= '0;
        end else begin
            was_run <= 1'b1;
            prev_k  <= local_tick;
            if (tx_valid && tx_ready) begin
                sent_any  <= 1'b1;
                last_sent <= tx_tick;
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !was_run |-> (local_tick == '0 && tx_valid && tx_tick == START));

    assert_first_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !sent_any) |-> (tx_tick == START));

    assert_hold_offer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_tick)));

    assert_counter_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        was_run |-> (local_tick >= prev_k));

    assert_consecutive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && sent_any) |-> (tx_tick == last_sent + W'(1)));

    assert_not_ahead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_tick <= local_tick));

endmodule

bind tick_pipe_node tick_pipe_node_chk #(.X(X), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_tick    (tx_tick),
    .local_tick (local_tick)
);

// File: tb/tb_tick_pipe_node.sv
module tb_tick_pipe_node;

    localparam int CLK_PERIOD = 10;
    localparam int F  = 1;
    localparam int X  = 2;
    localparam int W  = 16;
    localparam int SW = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rx_valid = 1'b0;
    logic [SW-1:0]       rx_src = '0;
    logic signed [W-1:0] rx_tick = '0;
    logic                tx_valid;
    logic                tx_ready = 1'b0;
    logic signed [W-1:0] tx_tick;
    logic signed [W-1:0] local_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int exp_q[$];

    tick_pipe_node #(.F(F), .X(X), .W(W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_src     (rx_src),
        .rx_tick    (rx_tick),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_tick    (tx_tick),
        .local_tick (local_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_tick(input int v);
        exp_q.push_back(v);
    endtask

    task automatic send(input int src, input int v);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_src   = SW'(src);
        rx_tick  = W'(v);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: each handshake about to happen is compared with the queue head.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected index", int'(tx_tick), 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(tx_tick) == e, "R2/R7/R10 sent index", int'(tx_tick), e);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state right after reset release.
        check(int'(local_tick) == 0, "R1 local_tick", int'(local_tick), 0);
        check(tx_valid == 1'b1, "R1 tx_valid", int'(tx_valid), 1);
        check(int'(tx_tick) == -X, "R1 tx_tick", int'(tx_tick), -X);

        // R3: offer held while not accepted.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(tx_valid && int'(tx_tick) == -X, "R3 held offer", int'(tx_tick), -X);
        end

        // R2: start-up run -X..0 then idle.
        for (int v = -X; v <= 0; v++) expect_tick(v);
        tx_ready = 1'b1;
        wait_drain();
        check(tx_valid == 1'b0, "R2 idle after start-up", int'(tx_valid), 0);
        check(int'(local_tick) == 0, "R2 local_tick after start-up", int'(local_tick), 0);

        // R6: two distinct peers (one repeated) at -2 do not reach 2F+1.
        send(0, -2);
        send(1, -2);
        send(1, -2);
        repeat (4) @(negedge clk);
        check(tx_valid == 1'b0, "R6 no advance on repeats", int'(tx_valid), 0);
        check(int'(local_tick) == 0, "R6 local_tick", int'(local_tick), 0);

        // R5 and R11: third peer at -X reaches k-X = -2, advance to 1.
        expect_tick(1);
        send(2, -2);
        wait_drain();
        check(int'(local_tick) == 1, "R5 R11 advance", int'(local_tick), 1);

        // R8 and R4: one peer ahead only; stale lower index ignored.
        send(0, 5);
        send(0, 3);
        repeat (4) @(negedge clk);
        check(tx_valid == 1'b0, "R8 single peer ahead", int'(tx_valid), 0);
        check(int'(local_tick) == 1, "R8 local_tick", int'(local_tick), 1);

        // R7: second peer at 4; target is 4 only if peer 0 still holds 5 (R4).
        tx_ready = 1'b0;
        for (int v = 2; v <= 9; v++) expect_tick(v);
        send(1, 4);
        repeat (3) @(negedge clk);
        check(tx_valid && int'(tx_tick) == 2, "R7 burst starts at k+1", int'(tx_tick), 2);
        check(int'(local_tick) == 4, "R7 R4 jump target", int'(local_tick), 4);

        // R10: new quorum arrives mid-burst and is not acted on.
        send(2, 9);
        send(3, 9);
        repeat (2) @(negedge clk);
        check(int'(local_tick) == 4, "R10 held off during burst", int'(local_tick), 4);
        check(int'(tx_tick) == 2, "R3 held during burst", int'(tx_tick), 2);

        // Release, then stop accepting right after index 4 goes out.
        tx_ready = 1'b1;
        while (!(tx_valid && tx_ready && int'(tx_tick) == 4)) @(negedge clk);
        @(negedge clk);
        tx_ready = 1'b0;
        while (!tx_valid) @(negedge clk);
        // R9: both rules hold (target 9, four peers >= 2); catch-up wins.
        check(int'(tx_tick) == 5, "R9 first index", int'(tx_tick), 5);
        check(int'(local_tick) == 9, "R9 catch-up priority", int'(local_tick), 9);
        tx_ready = 1'b1;
        wait_drain();
        check(int'(local_tick) == 9, "R7 after burst", int'(local_tick), 9);

        // R5: third peer reaches k-X = 7; advance to 10.
        expect_tick(10);
        send(0, 7);
        wait_drain();
        check(int'(local_tick) == 10, "R5 advance at 9", int'(local_tick), 10);
        check(tx_valid == 1'b0, "R10 idle at end", int'(tx_valid), 0);
        check(exp_q.size() == 0, "R10 all indices sent", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule